// File: doc/BRIEF.md
# Byte-Wide Runtime Control Register Window

This block gives a host processor a 256-byte window of control and status registers in its I/O address space. The window sits at a base address fixed by a parameter. The block compares the address bits above bit 7 with that base, and it decodes an access only while the host holds its I/O-space select high. Inside the window the low address byte is the register offset. Every transfer is a single byte.

Only 27 of the 256 offsets hold a register, so the map is sparse:
- 16 read/write control bytes sit at the even offsets 0x00 through 0x1E. Each one drives a byte of a flat output bus.
- 10 read-only status bytes sit at the even offsets 0x40 through 0x52. Each one returns the live value of a byte of a flat input bus.
- An 8-bit page register sits at offset 0xE0. Its value goes straight out to downstream decode logic and memory mapping, where it can also be used as general logic terms.

A read of any other offset returns 0x00, and a write to one is dropped. Read data is registered, so it appears one clock after the read access.

Top module: `csr_win_top`

## Requirements
- R1: While synchronous active-high reset is applied, the next clock edge clears page_out, every byte of ctrl_out and host_rdata to 0x00.
- R2: An access is decoded only when host_iosel is 1 and host_addr[15:8] equals the base address bits [15:8] (0x43 by default). Any other access changes no register, and host_rdata reads 0x00 on the following cycle.
- R3: A decoded write to offset 0xE0 loads host_wdata into page_out at that clock edge. A later read of 0xE0 returns it.
- R4: A decoded write to even offset 2*i (i = 0..15) loads control byte i, which appears on ctrl_out[8*i+7:8*i]. A read of that offset returns the stored byte.
- R5: A read of even offset 0x40+2*j (j = 0..9) returns stat_in[8*j+7:8*j] as sampled at the read edge. Writes to these offsets change nothing.
- R6: A read of any other offset returns 0x00. A write to any other offset changes no register.
- R7: host_rdata is registered. It carries the read value in the cycle after a decoded read, and 0x00 after any cycle without one.
- R8: When a decoded read and a decoded write to the same offset fall in one cycle, the read returns the value held before the write, and the write still takes effect.
- R9: Exactly 27 offsets are implemented, and each offset selects at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 16 | Host I/O address |
| host_iosel | input | 1 | I/O-space select strobe |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Registered read data byte |
| stat_in | input | 80 | Ten status bytes, byte j at bits 8*j+7:8*j |
| ctrl_out | output | 128 | Sixteen control bytes, byte i at bits 8*i+7:8*i |
| page_out | output | 8 | Page register value |

## Verification
A read and a write can fall in the same cycle, either to the same offset or to different ones. The bench provokes this on the page register and on control bytes by raising both strobes together. It judges the result against a behavioural model that takes the read value before it applies the write, and it compares host_rdata, page_out and ctrl_out on every clock. A second overlap is a reset applied while registers hold data: the bench checks that the reset wins and that every output returns to zero.

// File: rtl/csr_win_pkg.sv
`timescale 1ns/1ps
package csr_win_pkg;
  localparam int BYTE_W = 8;
  localparam int WIN_W  = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CTRL = 2'd1,
    KIND_STAT = 2'd2,
    KIND_PAGE = 2'd3
  } slot_kind_e;

  function automatic byte_t slot_ofs(input int unsigned first,
                                     input int unsigned stride,
                                     input int unsigned idx);
    int unsigned s;
    s = first + stride * idx;
    return byte_t'(s[WIN_W-1:0]);
  endfunction
endpackage

// File: rtl/csr_win_match.sv
`timescale 1ns/1ps
module csr_win_match
  import csr_win_pkg::*;
#(
  parameter int            ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4300
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iosel,
  output logic              hit,
  output byte_t             off
);
  localparam int TAG_W = ADDR_W - WIN_W;

  logic [TAG_W-1:0] tag_in;
  logic [TAG_W-1:0] tag_base;

  assign tag_in   = addr[ADDR_W-1:WIN_W];
  assign tag_base = BASE_ADDR[ADDR_W-1:WIN_W];
  assign hit      = iosel && (tag_in == tag_base);
  assign off      = addr[WIN_W-1:0];
endmodule

// File: rtl/csr_win_decode.sv
`timescale 1ns/1ps
module csr_win_decode
  import csr_win_pkg::*;
#(
  parameter int NUM_CTRL    = 16,
  parameter int NUM_STAT    = 10,
  parameter int CTRL_OFS0   = 'h00,
  parameter int CTRL_STRIDE = 2,
  parameter int STAT_OFS0   = 'h40,
  parameter int STAT_STRIDE = 2,
  parameter int PAGE_OFS    = 'hE0
) (
  input  byte_t               off,
  output logic [NUM_CTRL-1:0] ctrl_sel,
  output logic [NUM_STAT-1:0] stat_sel,
  output logic                page_sel,
  output slot_kind_e          kind
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
      assign ctrl_sel[gi] = (off == slot_ofs(CTRL_OFS0, CTRL_STRIDE, gi));
    end
    for (gi = 0; gi < NUM_STAT; gi++) begin : g_stat
      assign stat_sel[gi] = (off == slot_ofs(STAT_OFS0, STAT_STRIDE, gi));
    end
  endgenerate

  assign page_sel = (off == slot_ofs(PAGE_OFS, 0, 0));

  always_comb begin
    if (page_sel)        kind = KIND_PAGE;
    else if (|ctrl_sel)  kind = KIND_CTRL;
    else if (|stat_sel)  kind = KIND_STAT;
    else                 kind = KIND_NONE;
  end
endmodule

// File: rtl/csr_win_bank.sv
`timescale 1ns/1ps
module csr_win_bank
  import csr_win_pkg::*;
#(
  parameter int NUM = 16,
  localparam int FLAT_W = NUM * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NUM-1:0]    sel,
  input  byte_t             wdata,
  output logic [FLAT_W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM; gi++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)                q[gi*BYTE_W +: BYTE_W] <= '0;
        else if (we && sel[gi]) q[gi*BYTE_W +: BYTE_W] <= wdata;
      end

      // R4: a selected write lands in exactly this byte
      a_r4_byte_load: assert property (@(posedge clk) disable iff (rst)
        (we && sel[gi]) |=> (q[gi*BYTE_W +: BYTE_W] == $past(wdata)));

      // R6: an unselected byte keeps its value
      a_r6_byte_hold: assert property (@(posedge clk) disable iff (rst)
        !(we && sel[gi]) |=> $stable(q[gi*BYTE_W +: BYTE_W]));
    end
  endgenerate
endmodule

// File: rtl/csr_win_top.sv
`timescale 1ns/1ps
module csr_win_top
  import csr_win_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h4300,
  parameter int                NUM_CTRL    = 16,
  parameter int                NUM_STAT    = 10,
  parameter int                CTRL_OFS0   = 'h00,
  parameter int                CTRL_STRIDE = 2,
  parameter int                STAT_OFS0   = 'h40,
  parameter int                STAT_STRIDE = 2,
  parameter int                PAGE_OFS    = 'hE0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic                       host_iosel,
  input  logic                       host_rd,
  input  logic                       host_wr,
  input  logic [7:0]                 host_wdata,
  output logic [7:0]                 host_rdata,
  input  logic [NUM_STAT*8-1:0]      stat_in,
  output logic [NUM_CTRL*8-1:0]      ctrl_out,
  output logic [7:0]                 page_out
);
  logic                hit;
  byte_t               off;
  logic [NUM_CTRL-1:0] ctrl_sel;
  logic [NUM_STAT-1:0] stat_sel;
  logic                page_sel;
  slot_kind_e          kind;
  logic                do_wr;
  logic                do_rd;
  byte_t               rd_mux;

  csr_win_match #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_match (
    .addr (host_addr),
    .iosel(host_iosel),
    .hit  (hit),
    .off  (off)
  );

  csr_win_decode #(
    .NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT),
    .CTRL_OFS0(CTRL_OFS0), .CTRL_STRIDE(CTRL_STRIDE),
    .STAT_OFS0(STAT_OFS0), .STAT_STRIDE(STAT_STRIDE),
    .PAGE_OFS(PAGE_OFS)
  ) u_dec (
    .off     (off),
    .ctrl_sel(ctrl_sel),
    .stat_sel(stat_sel),
    .page_sel(page_sel),
    .kind    (kind)
  );

  assign do_wr = hit && host_wr;
  assign do_rd = hit && host_rd;

  csr_win_bank #(.NUM(NUM_CTRL)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .we   (do_wr),
    .sel  (ctrl_sel),
    .wdata(host_wdata),
    .q    (ctrl_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                        page_out <= '0;
    else if (do_wr && page_sel)     page_out <= host_wdata;
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      KIND_PAGE: rd_mux = page_out;
      KIND_CTRL: begin
        for (int i = 0; i < NUM_CTRL; i++)
          if (ctrl_sel[i]) rd_mux = rd_mux | ctrl_out[i*BYTE_W +: BYTE_W];
      end
      KIND_STAT: begin
        for (int j = 0; j < NUM_STAT; j++)
          if (stat_sel[j]) rd_mux = rd_mux | stat_in[j*BYTE_W +: BYTE_W];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        host_rdata <= '0;
    else if (do_rd) host_rdata <= rd_mux;
    else            host_rdata <= '0;
  end

  // R1: reset clears every output register
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (page_out == 8'h00 && host_rdata == 8'h00 && ctrl_out == '0));

  // R2: nothing outside the window touches state
  a_r2_outside_hold: assert property (@(posedge clk) disable iff (rst)
    !(hit && host_wr) |=> ($stable(page_out) && $stable(ctrl_out)));

  // R3: page load
  a_r3_page_load: assert property (@(posedge clk) disable iff (rst)
    (hit && host_wr && page_sel) |=> (page_out == $past(host_wdata)));

  // R7: idle cycles return zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(hit && host_rd) |=> (host_rdata == 8'h00));

  // R8: same-cycle read of the page register sees the old value
  a_r8_read_old: assert property (@(posedge clk) disable iff (rst)
    (hit && host_rd && host_wr && page_sel) |=> (host_rdata == $past(page_out)));

  // R9: an offset never selects two registers
  a_r9_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_sel, stat_sel, page_sel}));
endmodule

// File: tb/tb_csr_win_top.sv
`timescale 1ns/1ps
module tb_csr_win_top;
  localparam int NC = 16;
  localparam int NS = 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [15:0]       host_addr;
  logic              host_iosel, host_rd, host_wr;
  logic [7:0]        host_wdata;
  logic [7:0]        host_rdata;
  logic [NS*8-1:0]   stat_in;
  logic [NC*8-1:0]   ctrl_out;
  logic [7:0]        page_out;

  always #10 clk = ~clk;

  csr_win_top dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_iosel(host_iosel),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .stat_in(stat_in), .ctrl_out(ctrl_out),
    .page_out(page_out)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  string req   = "R1";

  logic [7:0] m_ctrl [NC];
  logic [7:0] m_page;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_read(input logic [7:0] o);
    if (o == 8'hE0) return m_page;
    if (o < 8'h20 && !o[0]) return m_ctrl[int'(o >> 1)];
    if (o >= 8'h40 && o < 8'h54 && !o[0]) return stat_in[int'((o - 8'h40) >> 1) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic chk(input string r, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    logic       hit;
    logic [7:0] o;
    logic [7:0] v;
    logic [127:0] ec;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NC; i++) m_ctrl[i] = 8'h00;
      m_page = 8'h00;
      m_rd   = 8'h00;
    end else begin
      hit  = host_iosel && (host_addr[15:8] == 8'h43);
      o    = host_addr[7:0];
      v    = m_read(o);
      m_rd = (hit && host_rd) ? v : 8'h00;
      if (hit && host_wr) begin
        if (o == 8'hE0) m_page = host_wdata;
        else if (o < 8'h20 && !o[0]) m_ctrl[int'(o >> 1)] = host_wdata;
      end
    end
    @(negedge clk);
    for (int i = 0; i < NC; i++) ec[i*8 +: 8] = m_ctrl[i];
    chk(req, "rdata", {120'd0, host_rdata}, {120'd0, m_rd});
    chk(req, "page",  {120'd0, page_out},   {120'd0, m_page});
    chk(req, "ctrl",  ctrl_out, ec);
  endtask

  task automatic acc(input logic [15:0] a, input logic sel,
                     input logic rd, input logic wr, input logic [7:0] d);
    host_addr = a; host_iosel = sel; host_rd = rd; host_wr = wr; host_wdata = d;
    tick();
    host_iosel = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nz;
    rst = 1'b1; host_addr = '0; host_iosel = 0; host_rd = 0; host_wr = 0;
    host_wdata = '0;
    for (int j = 0; j < NS; j++) stat_in[j*8 +: 8] = 8'h30 + 8'(j);
    @(negedge clk);
    req = "R1"; tick(); tick();
    rst = 1'b0;

    req = "R3";
    acc(16'h43E0, 1, 0, 1, 8'h5C);
    acc(16'h43E0, 1, 1, 0, 8'h00);

    req = "R4";
    for (int i = 0; i < NC; i++) acc(16'h4300 + 16'(2*i), 1, 0, 1, 8'hA0 ^ 8'(i*7));
    for (int i = 0; i < NC; i++) acc(16'h4300 + 16'(2*i), 1, 1, 0, 8'h00);

    req = "R5";
    for (int j = 0; j < NS; j++) acc(16'h4340 + 16'(2*j), 1, 1, 0, 8'h00);
    acc(16'h4342, 1, 0, 1, 8'hEE);
    acc(16'h4342, 1, 1, 0, 8'h00);
    stat_in[3*8 +: 8] = 8'hC3;
    acc(16'h4346, 1, 1, 0, 8'h00);

    req = "R6";
    acc(16'h4301, 1, 0, 1, 8'h77);
    acc(16'h4330, 1, 0, 1, 8'h77);
    acc(16'h43E1, 1, 0, 1, 8'h77);
    acc(16'h4301, 1, 1, 0, 8'h00);
    acc(16'h43FF, 1, 1, 0, 8'h00);

    req = "R2";
    acc(16'h44E0, 1, 1, 1, 8'h11);
    acc(16'h43E0, 0, 1, 1, 8'h22);
    acc(16'h0300, 1, 1, 1, 8'h33);
    acc(16'hC302, 1, 0, 1, 8'h44);

    req = "R7";
    tick(); tick();
    acc(16'h43E0, 1, 1, 0, 8'h00);
    tick();

    req = "R8";
    acc(16'h43E0, 1, 1, 1, 8'h9D);
    acc(16'h43E0, 1, 1, 1, 8'h13);
    acc(16'h4306, 1, 1, 1, 8'h6B);
    acc(16'h4306, 1, 1, 0, 8'h00);

    req = "R1";
    rst = 1'b1; tick(); rst = 1'b0; tick();

    req = "R9";
    for (int j = 0; j < NS; j++) stat_in[j*8 +: 8] = 8'h5A;
    for (int k = 0; k < 256; k++) acc(16'h4300 + 16'(k), 1, 0, 1, 8'hFF);
    nz = 0;
    for (int k = 0; k < 256; k++) begin
      acc(16'h4300 + 16'(k), 1, 1, 0, 8'h00);
      if (host_rdata != 8'h00) nz++;
    end
    chk("R9", "implemented count", 128'(nz), 128'd27);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule